// File: doc/BRIEF.md
# SD Card Clock Generator with Self-Clearing Reset

This block derives the SD card clock from a base clock. Software controls it through one 16-bit control word. The word holds three things: an internal clock enable, a card clock enable, and a divisor that is split across two fields. A mode input selects how the divisor is read. In the older power-of-two scheme, only an 8-bit field is used, and its highest set bit picks the ratio. In the 10-bit scheme, the two fields join into a value N, and the base clock is divided by 2N with an even duty cycle. In both schemes a divisor of zero passes the base clock straight through.

After the internal clock enable is set, or after the divisor changes while the enable is set, a settle counter runs. The stable flag comes up only when the counter finishes. The card clock leaves the block only when the card clock enable and the stable flag are both set. The gate opens and closes only while the output is low, so no shortened pulse ever reaches the card. A software driver stops the clock by clearing the card clock enable. To change frequency, the driver stops the clock, writes the new divisor, waits for the stable flag and enables the clock again.

A separate reset-all request clears the whole control word. The reset stays busy for a fixed number of cycles and then clears itself.

Top module: `sd_clk_ctrl`

## Requirements
- R1: The control word places the internal clock enable at bit 0, the card clock enable at bit 2, divisor bits 7:0 at word bits 15:8 and divisor bits 9:8 at word bits 7:6. Read-back shows these fields, with bits 5:3 as zero. After reset the read-back is 0000h.
- R2: Bit 1 of the read-back is the stable flag. A value written to bit 1 has no effect.
- R3: The stable flag rises STABLE_CYCLES base-clock edges after the edge that stores the internal clock enable going from 0 to 1, or a changed divisor while the enable is 1. It reads 0 from the same cycle in which the enable reads 0.
- R4: With the mode input low, a one-hot code 2^k in word bits 15:8 divides the base clock by 2^(k+1) with a 50% duty cycle. Word bits 7:6 are ignored in this mode.
- R5: With the mode input low, a code in bits 15:8 that is not one-hot acts as its highest set bit alone.
- R6: With the mode input high, a divisor N from 1 to 3FFh divides the base clock by 2N with a 50% duty cycle.
- R7: A divisor of zero (bits 15:8 in power-of-two mode, all ten bits in 10-bit mode) passes the base clock to the output, gated on its low phase.
- R8: The output stays low unless both the card clock enable and the stable flag are 1. When either drops during a high phase, that high phase still runs to its full length.
- R9: A reset-all request clears the control word and raises a busy flag for RST_CYCLES cycles. Writes made while busy is high are ignored, and busy then clears itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ten_bit_mode | input | 1 | 1 selects the 10-bit divided mode, 0 the power-of-two mode |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word value to write |
| rst_all_req | input | 1 | Request for a reset of all control state |
| rd_data | output | 16 | Control word read-back, including the stable flag |
| rst_all_busy | output | 1 | High while a reset-all is in progress |
| clk_stable | output | 1 | Internal clock stable flag |
| sd_clk_out | output | 1 | Gated card clock |

## Verification
The hardest case to reach from the ports is a clock that is shut off, or that changes divisor, in the middle of a high phase. The write has to land while the divided output is high, and the gating rule must then stretch that phase to its full length. The stimulus gets there by writing at fixed cycle offsets into long divided periods, with a half-period of 16 in power-of-two mode. It also changes the divisor while the clock is running in 10-bit mode. A cycle model in the bench compares the output in both clock phases, so pass-through gating is checked in the high phase as well.

// File: rtl/sd_clk_pkg.sv
package sd_clk_pkg;
   localparam int DIV_LO_W = 8;
   localparam int DIV_HI_W = 2;
   localparam int DIV_W    = DIV_LO_W + DIV_HI_W;
   localparam int CTRL_W   = 16;

   typedef struct packed {
      logic [DIV_LO_W-1:0] div_lo;
      logic [DIV_HI_W-1:0] div_hi;
      logic                sd_en;
      logic                ice;
   } ctrl_t;

   // Half period for the power-of-two code: highest set bit wins.
   function automatic logic [DIV_W-1:0] pow2_half(input logic [DIV_LO_W-1:0] code);
      logic [DIV_W-1:0] res;
      res = '0;
      for (int i = 0; i < DIV_LO_W; i++) begin
         if (code[i]) res = DIV_W'(1) << i;
      end
      return res;
   endfunction
endpackage

// File: rtl/sd_clk_regs.sv
module sd_clk_regs
   import sd_clk_pkg::*;
#(
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CTRL_W-1:0] wr_data,
   input  logic              rst_all_req,
   output ctrl_t             ctrl_q,
   output logic              restart,
   output logic              busy_q
);
   localparam int BC_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

   logic [BC_W-1:0] bcnt_q;
   ctrl_t           ctrl_nxt;
   logic            accept;
   logic            unused_bits;

   assign unused_bits = ^{wr_data[5:3], wr_data[1]};

   always_comb begin
      ctrl_nxt.div_lo = wr_data[15:8];
      ctrl_nxt.div_hi = wr_data[7:6];
      ctrl_nxt.sd_en  = wr_data[2];
      ctrl_nxt.ice    = wr_data[0];
   end

   assign accept  = wr_en && !busy_q && !rst_all_req;
   assign restart = accept && ctrl_nxt.ice &&
                    (!ctrl_q.ice || {ctrl_nxt.div_hi, ctrl_nxt.div_lo} != {ctrl_q.div_hi, ctrl_q.div_lo});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         busy_q <= 1'b0;
         bcnt_q <= '0;
      end else if (!busy_q && rst_all_req) begin
         ctrl_q <= '0;
         busy_q <= 1'b1;
         bcnt_q <= '0;
      end else if (busy_q) begin
         if (bcnt_q == BC_W'(RST_CYCLES - 1)) busy_q <= 1'b0;
         else                                 bcnt_q <= bcnt_q + 1'b1;
      end else if (accept) begin
         ctrl_q <= ctrl_nxt;
      end
   end

   a_r9_ctrl_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> ctrl_q == '0);
   a_r9_write_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> $stable(ctrl_q));
   a_r1_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ctrl_q.ice == $past(wr_data[0]) && ctrl_q.sd_en == $past(wr_data[2]));
endmodule

// File: rtl/sd_clk_stable.sv
module sd_clk_stable #(
   parameter int STABLE_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ice_q,
   input  logic restart,
   output logic stable_o
);
   localparam int SC_W = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;

   logic [SC_W-1:0] cnt_q;
   logic            stable_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         stable_q <= 1'b0;
      end else if (restart || !ice_q) begin
         cnt_q    <= '0;
         stable_q <= 1'b0;
      end else if (!stable_q) begin
         if (cnt_q == SC_W'(STABLE_CYCLES - 1)) stable_q <= 1'b1;
         else                                   cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign stable_o = stable_q && ice_q;

   a_r3_restart_clears : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !stable_o);
   a_r3_rise_needs_ice : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stable_o) |-> $past(ice_q));
endmodule

// File: rtl/sd_clk_divsel.sv
module sd_clk_divsel
   import sd_clk_pkg::*;
#(
   parameter bit SUPPORT_POW2 = 1'b1
) (
   input  ctrl_t            ctrl,
   input  logic             ten_bit_mode,
   output logic [DIV_W-1:0] half,
   output logic             bypass
);
   logic [DIV_W-1:0] full_n;
   logic             ten_sel;
   logic             unused_mode;

   assign full_n = {ctrl.div_hi, ctrl.div_lo};

   generate
      if (SUPPORT_POW2) begin : g_both
         assign ten_sel     = ten_bit_mode;
         assign unused_mode = 1'b0;
      end else begin : g_ten_only
         assign ten_sel     = 1'b1;
         assign unused_mode = ten_bit_mode;
      end
   endgenerate

   always_comb begin
      if (ten_sel) begin
         bypass = (full_n == '0);
         half   = bypass ? DIV_W'(1) : full_n;
      end else begin
         bypass = (ctrl.div_lo == '0);
         half   = bypass ? DIV_W'(1) : pow2_half(ctrl.div_lo);
      end
   end
endmodule

// File: rtl/sd_clk_div.sv
module sd_clk_div #(
   parameter int HALF_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [HALF_W-1:0] half,
   output logic              div_q
);
   logic [HALF_W-1:0] hcnt_q;
   logic              term;

   assign term = (hcnt_q >= half - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= 1'b0;
         hcnt_q <= '0;
      end else if (div_q) begin
         if (term) begin
            div_q  <= 1'b0;
            hcnt_q <= '0;
         end else begin
            hcnt_q <= hcnt_q + 1'b1;
         end
      end else if (!en) begin
         hcnt_q <= '0;
      end else if (term) begin
         div_q  <= 1'b1;
         hcnt_q <= '0;
      end else begin
         hcnt_q <= hcnt_q + 1'b1;
      end
   end

   a_r8_stay_low : assert property (@(posedge clk) disable iff (!rst_n)
      (!div_q && !en) |=> !div_q);
   a_r6_rise_needs_en : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(div_q) |-> $past(en));
endmodule

// File: rtl/sd_clk_ctrl.sv
module sd_clk_ctrl
   import sd_clk_pkg::*;
#(
   parameter int STABLE_CYCLES = 8,
   parameter int RST_CYCLES    = 4,
   parameter bit SUPPORT_POW2  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ten_bit_mode,
   input  logic        wr_en,
   input  logic [15:0] wr_data,
   input  logic        rst_all_req,
   output logic [15:0] rd_data,
   output logic        rst_all_busy,
   output logic        clk_stable,
   output logic        sd_clk_out
);
   generate
      if (STABLE_CYCLES < 1) begin : g_bad_stable
         $error("STABLE_CYCLES must be at least 1");
      end
      if (RST_CYCLES < 1) begin : g_bad_rst
         $error("RST_CYCLES must be at least 1");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic             restart;
   logic             stable;
   logic [DIV_W-1:0] half;
   logic             bypass;
   logic             div_en;
   logic             div_q;
   logic             byp_gate_q;

   sd_clk_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rst_all_req(rst_all_req), .ctrl_q(ctrl_q), .restart(restart), .busy_q(rst_all_busy));

   sd_clk_stable #(.STABLE_CYCLES(STABLE_CYCLES)) u_stable (
      .clk(clk), .rst_n(rst_n), .ice_q(ctrl_q.ice), .restart(restart), .stable_o(stable));

   sd_clk_divsel #(.SUPPORT_POW2(SUPPORT_POW2)) u_divsel (
      .ctrl(ctrl_q), .ten_bit_mode(ten_bit_mode), .half(half), .bypass(bypass));

   assign div_en = ctrl_q.sd_en && stable && !bypass;

   sd_clk_div #(.HALF_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(div_en), .half(half), .div_q(div_q));

   // Pass-through gate changes only while the base clock is low.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) byp_gate_q <= 1'b0;
      else        byp_gate_q <= ctrl_q.sd_en && stable && bypass;
   end

   assign sd_clk_out = (clk && byp_gate_q) || div_q;
   assign clk_stable = stable;
   assign rd_data    = {ctrl_q.div_lo, ctrl_q.div_hi, 3'b000, ctrl_q.sd_en, stable, ctrl_q.ice};

   a_r7_div_idle_in_bypass : assert property (@(posedge clk) disable iff (!rst_n)
      (bypass && !div_q) |=> !div_q);
   a_r8_gate_needs_enable : assert property (@(negedge clk) disable iff (!rst_n)
      byp_gate_q |-> $past(ctrl_q.sd_en));
   a_r2_stable_bit_follows : assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[1] == clk_stable);
endmodule

// File: tb/sd_clk_ctrl_tb_top.sv
module sd_clk_ctrl_tb_top;
   localparam int STABLE = 8;
   localparam int RSTC   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ten_bit_mode = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rst_all_req = 1'b0;
   logic [15:0] rd_data;
   logic        rst_all_busy;
   logic        clk_stable;
   logic        sd_clk_out;

   int    n_tests = 0;
   int    n_fail  = 0;
   string cur_req = "R1";
   bit    done    = 1'b0;

   always #10 clk = ~clk;

   sd_clk_ctrl #(.STABLE_CYCLES(STABLE), .RST_CYCLES(RSTC)) dut_i (
      .clk(clk), .rst_n(rst_n), .ten_bit_mode(ten_bit_mode), .wr_en(wr_en),
      .wr_data(wr_data), .rst_all_req(rst_all_req), .rd_data(rd_data),
      .rst_all_busy(rst_all_busy), .clk_stable(clk_stable), .sd_clk_out(sd_clk_out));

   // ---------------- reference model ----------------
   bit m_ice, m_sden, m_st, m_busy, m_dq, m_bg;
   int m_div, m_sc, m_bc, m_hc;

   function automatic int f_half(int dv, bit ten);
      int lo, h;
      lo = dv % 256;
      if (ten) return (dv == 0) ? 1 : dv;
      if (lo == 0) return 1;
      h = 1;
      while (lo > 1) begin lo = lo / 2; h = h * 2; end
      return h;
   endfunction

   function automatic bit f_byp(int dv, bit ten);
      return ten ? (dv == 0) : ((dv % 256) == 0);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ice = 0; m_sden = 0; m_st = 0; m_busy = 0; m_dq = 0;
         m_div = 0; m_sc = 0; m_bc = 0; m_hc = 0;
      end else begin
         bit o_ice, o_sden, o_st, rs, en;
         int o_div, nd, hf;
         o_ice = m_ice; o_sden = m_sden; o_st = m_st; o_div = m_div; rs = 0;
         if (!m_busy && rst_all_req) begin
            m_busy = 1; m_bc = 0; m_ice = 0; m_sden = 0; m_div = 0;
         end else if (m_busy) begin
            if (m_bc == RSTC - 1) m_busy = 0; else m_bc++;
         end else if (wr_en) begin
            nd = int'(wr_data[7:6]) * 256 + int'(wr_data[15:8]);
            rs = wr_data[0] && (!o_ice || nd != o_div);
            m_ice = wr_data[0]; m_sden = wr_data[2]; m_div = nd;
         end
         if (rs || !o_ice) begin m_st = 0; m_sc = 0; end
         else if (!m_st) begin if (m_sc == STABLE - 1) m_st = 1; else m_sc++; end
         hf = f_half(o_div, ten_bit_mode);
         en = o_sden && o_st && o_ice && !f_byp(o_div, ten_bit_mode);
         if (m_dq) begin
            if (m_hc >= hf - 1) begin m_dq = 0; m_hc = 0; end else m_hc++;
         end else if (!en) m_hc = 0;
         else if (m_hc >= hf - 1) begin m_dq = 1; m_hc = 0; end
         else m_hc++;
      end
   end

   always @(negedge clk or negedge rst_n) begin
      if (!rst_n) m_bg = 0;
      else        m_bg = m_sden && m_st && m_ice && f_byp(m_div, ten_bit_mode);
   end

   task automatic chk(string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         chk("rd_data", int'(rd_data),
             (m_div % 256) * 256 + (m_div / 256) * 64 + int'(m_sden) * 4 + int'(m_st && m_ice) * 2 + int'(m_ice));
         chk("clk_stable", int'(clk_stable), int'(m_st && m_ice));
         chk("rst_all_busy", int'(rst_all_busy), int'(m_busy));
         chk("sd_clk_out high phase", int'(sd_clk_out), int'(m_bg || m_dq));
      end
   end

   always @(negedge clk) begin
      #5;
      if (rst_n && !done) chk("sd_clk_out low phase", int'(sd_clk_out), int'(m_dq));
   end

   // ---------------- stimulus ----------------
   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [15:0] d);
      @(negedge clk); #1 wr_en = 1'b1; wr_data = d;
      @(negedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic finish_sim;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_sim();
      end
   end

   initial begin
      run(3);
      #1 rst_n = 1'b1;
      run(2);
      cur_req = "R1"; chk("reset rd_data", int'(rd_data), 0);
      // R4: one-hot 04h -> divide by 8
      cur_req = "R4"; wr(16'h0401); run(12); wr(16'h0405); run(40);
      // R2: written bit 1 has no effect
      cur_req = "R2"; wr(16'h0407); run(6); wr(16'h0002); run(4);
      chk("R2 bit1 ignored", int'(rd_data[1]), 0);
      // R5: non-one-hot 16h acts as 10h; R4 upper bits ignored
      cur_req = "R5"; wr(16'h16C1); run(12); wr(16'h16C5); run(70);
      // R8: stop in mid high phase, then low-phase gating
      cur_req = "R8"; wr(16'h16C1); run(40); wr(16'h16C5); run(45);
      wr(16'h16C1); run(40);
      // R3: divisor change while running, then drop of enable
      cur_req = "R3"; wr(16'h08C5); run(30); wr(16'h08C4); run(3);
      chk("R3 stable drops with enable", int'(clk_stable), 0);
      wr(16'h0000); run(2);
      // R6: ten-bit mode, N=3 then N=100h
      ten_bit_mode = 1'b1;
      cur_req = "R6"; wr(16'h0301); run(12); wr(16'h0305); run(40);
      wr(16'h0045); run(1100);
      // R7: divisor zero passes the base clock in both modes
      cur_req = "R7"; wr(16'h0001); run(1100); wr(16'h0005); run(20);
      wr(16'h0000); #1 ten_bit_mode = 1'b0;
      wr(16'h00C1); run(12); wr(16'h00C5); run(20);
      // R9: reset-all while running, with a write during busy
      cur_req = "R9"; wr(16'h0205); run(20);
      @(negedge clk); #1 rst_all_req = 1'b1;
      @(negedge clk); #1 rst_all_req = 1'b0; wr_en = 1'b1; wr_data = 16'h0405;
      @(negedge clk); #1 wr_en = 1'b0;
      run(RSTC + 4);
      chk("R9 ctrl cleared", int'(rd_data), 0);
      chk("R9 busy self-cleared", int'(rst_all_busy), 0);
      run(4);
      finish_sim();
   end
endmodule